// File: doc/BRIEF.md
# Serial Control Register Bank

This block receives configuration writes over a three-wire, write-only serial port: an active-low load/enable strobe, a shift clock and a data line. Each write is a 12-bit frame made of a 4-bit register address followed by an 8-bit data byte. The frame is applied when the load strobe returns high. All three serial pins are asynchronous to the system clock. They are synchronised into the system clock domain and their edges are detected there, so each high and each low phase of the serial pins must last at least three system clocks.

The decoded register contents appear as parallel field outputs: amplifier gain code, black-level target, two aperture-delay codes, clock/polarity options, control bits, calibration options, a 10-bit fine offset DAC value written in two halves, and a 4-bit coarse offset DAC value. One address holds a self-clearing reset bit. Writing a 1 to it raises a soft-reset pulse of fixed length. That pulse returns every register to its default value and is also driven out, so downstream calibration state can clear along with the registers. There is no read-back path.

Top module: `ser_ctrl_regs`

## Requirements
- R1: While `ser_load` is low, each rising edge of `ser_clk` shifts in `ser_din`. The first 4 bits form the address and the next 8 form the data, both MSB first. A rising edge of `ser_load` applies the frame, and the outputs show the result within 6 system clocks of that edge.
- R2: After `rst_n` is released, the outputs hold these values: gain 0, target 32, both delay codes 0, clock options 0x10, control 0x1, calibration 0x0C, fine DAC 0, coarse DAC 0. `soft_rst` is 0.
- R3: Address 0 writes all 8 bits of the gain code. Address 1 writes data bits 5:0 into the target offset, and data bits 7:6 are discarded.
- R4: Address 2 writes data bits 7:5 into the black-sample delay and data bits 4:2 into the pixel-sample delay. Data bits 1:0 are discarded.
- R5: Address 3 writes data bits 6:0 into the clock options: bit 6 is reset reject, bit 4 is clamp option, and bits 3:0 are polarities. Address 4 writes data bits 3:0 into the control bits: bit 0 is output enable, bit 1 is power down, bit 2 is ADC-input test and bit 3 is delay test. Address 5 writes data bits 4:0 into the calibration options: bit 0 is manual DAC, bit 1 is filter width, bit 2 is filter on, bit 3 is speed-up and bit 4 is hold.
- R6: Address 6 writes fine DAC bits 9:2 from data bits 7:0. Address 7 writes fine DAC bits 1:0 from data bits 1:0. Each write leaves the other part of the fine DAC value unchanged. Address 8 writes the coarse DAC from data bits 3:0.
- R7: A frame to addresses 9 to 14, or to address 15 with data bit 0 clear, changes no output.
- R8: A frame that ends with a count of `ser_clk` rising edges other than 12 changes no output.
- R9: A frame to address 15 with data bit 0 set drives `soft_rst` high for exactly 4 system clocks. Every register then returns to its R2 default, and `soft_rst` clears itself.
- R10: Setting the power-down bit (address 4, bit 1) keeps all other register values. Frames written while power-down is set still take effect.
- R11: Rising edges of `ser_clk` while `ser_load` is high are ignored and do not count toward the next frame.
- R12: If a rising edge of `ser_load` and a rising edge of `ser_clk` land in the same synchronised cycle, the load edge wins. A 12-bit frame is applied and the shift-clock edge is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, data sampled on its rising edge |
| ser_din | input | 1 | Serial data |
| ser_load | input | 1 | Low enables shifting; rising edge applies the frame |
| gain_code | output | 8 | Amplifier gain code |
| tgt_offset | output | 6 | Black-level target |
| blk_dly | output | 3 | Black-sample aperture delay code |
| pix_dly | output | 3 | Pixel-sample aperture delay code |
| clk_opts | output | 7 | Clock, clamp and polarity options |
| ctl_bits | output | 4 | Output enable, power down, ADC-input test, delay test |
| cal_bits | output | 5 | Calibration options |
| fine_dac | output | 10 | Fine offset DAC value |
| coarse_dac | output | 4 | Coarse offset DAC value |
| soft_rst | output | 1 | Self-clearing soft-reset pulse |

## Verification
Two functions can land in the same system-clock cycle: applying a frame on the load edge and counting a shift-clock edge. The bench creates this overlap by sending twelve bits and then raising `ser_clk` and `ser_load` on the same clock edge, so both pass through equal synchroniser depth. The overlap is judged at the outputs. The frame's data must appear, because the load edge must win; if the extra edge were counted, the frame would hold 13 bits and be dropped. A second overlap, between a register write and the soft-reset pulse, is covered by an assertion that registers are at their defaults on the cycle after every pulse cycle.

// File: rtl/ser_regs_pkg.sv
package ser_regs_pkg;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = ADDR_W + DATA_W;

  localparam logic [ADDR_W-1:0] A_GAIN = 4'd0;
  localparam logic [ADDR_W-1:0] A_TGT  = 4'd1;
  localparam logic [ADDR_W-1:0] A_DLY  = 4'd2;
  localparam logic [ADDR_W-1:0] A_CLK  = 4'd3;
  localparam logic [ADDR_W-1:0] A_CTL  = 4'd4;
  localparam logic [ADDR_W-1:0] A_CAL  = 4'd5;
  localparam logic [ADDR_W-1:0] A_FHI  = 4'd6;
  localparam logic [ADDR_W-1:0] A_FLO  = 4'd7;
  localparam logic [ADDR_W-1:0] A_CRS  = 4'd8;
  localparam logic [ADDR_W-1:0] A_RST  = 4'd15;

  localparam logic [7:0] D_GAIN = 8'd0;
  localparam logic [5:0] D_TGT  = 6'd32;
  localparam logic [6:0] D_CLK  = 7'h10;
  localparam logic [3:0] D_CTL  = 4'h1;
  localparam logic [4:0] D_CAL  = 5'h0C;

  // Writes that touch at least one stored bit.
  function automatic logic has_effect(input logic [ADDR_W-1:0] a,
                                      input logic [DATA_W-1:0] d);
    return (a <= A_CRS) || (a == A_RST && d[0]);
  endfunction

  // Replace the two low bits of the fine DAC value.
  function automatic logic [9:0] fine_lo(input logic [9:0] cur,
                                         input logic [DATA_W-1:0] d);
    return {cur[9:2], d[1:0]};
  endfunction

  // Replace the eight high bits of the fine DAC value.
  function automatic logic [9:0] fine_hi(input logic [9:0] cur,
                                         input logic [DATA_W-1:0] d);
    return {d, cur[1:0]};
  endfunction
endpackage

// File: rtl/ser_edge_sync.sv
module ser_edge_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] s1, s2, s3;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1[i] <= 1'b1;
        s2[i] <= 1'b1;
        s3[i] <= 1'b1;
      end else begin
        s1[i] <= pin[i];
        s2[i] <= s1[i];
        s3[i] <= s2[i];
      end
    end
    assign lvl[i]  = s2[i];
    assign rise[i] = s2[i] & ~s3[i];
  end
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter
  import ser_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din_lvl,
  input  logic              sclk_rise,
  input  logic              load_lvl,
  input  logic              load_rise,
  output logic              frame_wr,
  output logic [ADDR_W-1:0] frame_addr,
  output logic [DATA_W-1:0] frame_data
);
  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;
  logic               shift_en;
  logic               full_frame;

  assign shift_en   = sclk_rise && !load_lvl && !load_rise;
  assign full_frame = (cnt == CNT_W'(FRAME_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      cnt      <= '0;
      frame_wr <= 1'b0;
    end else begin
      frame_wr <= load_rise && full_frame;
      if (load_rise) begin
        cnt <= '0;
      end else if (shift_en) begin
        shreg <= {shreg[FRAME_W-2:0], din_lvl};
        if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
      end
    end
  end

  assign frame_addr = shreg[FRAME_W-1:DATA_W];
  assign frame_data = shreg[DATA_W-1:0];

  // R1: a commit strobe lasts one cycle and follows a load edge
  p_single_commit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wr |=> !frame_wr);
  p_commit_after_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wr |-> $past(load_rise));
  // R11: no shifting while the load strobe is high
  p_frozen_when_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_lvl) && load_lvl |-> $stable(shreg));
endmodule

// File: rtl/ser_reg_bank.sv
module ser_reg_bank
  import ser_regs_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [7:0]        gain_code,
  output logic [5:0]        tgt_offset,
  output logic [2:0]        blk_dly,
  output logic [2:0]        pix_dly,
  output logic [6:0]        clk_opts,
  output logic [3:0]        ctl_bits,
  output logic [4:0]        cal_bits,
  output logic [9:0]        fine_dac,
  output logic [3:0]        coarse_dac,
  output logic              soft_rst
);
  localparam int RC_W = $clog2(RST_CYCLES + 1);

  logic [RC_W-1:0] rst_cnt;
  logic            rst_req;

  assign rst_req  = wr && (addr == A_RST) && data[0];
  assign soft_rst = (rst_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_cnt <= '0;
    else if (rst_req) rst_cnt <= RC_W'(RST_CYCLES);
    else if (soft_rst) rst_cnt <= rst_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || soft_rst) begin
      gain_code  <= D_GAIN;
      tgt_offset <= D_TGT;
      blk_dly    <= '0;
      pix_dly    <= '0;
      clk_opts   <= D_CLK;
      ctl_bits   <= D_CTL;
      cal_bits   <= D_CAL;
      fine_dac   <= '0;
      coarse_dac <= '0;
    end else if (wr) begin
      case (addr)
        A_GAIN: gain_code  <= data;
        A_TGT:  tgt_offset <= data[5:0];
        A_DLY:  {blk_dly, pix_dly} <= data[7:2];
        A_CLK:  clk_opts   <= data[6:0];
        A_CTL:  ctl_bits   <= data[3:0];
        A_CAL:  cal_bits   <= data[4:0];
        A_FHI:  fine_dac   <= fine_hi(fine_dac, data);
        A_FLO:  fine_dac   <= fine_lo(fine_dac, data);
        A_CRS:  coarse_dac <= data[3:0];
        default: ;
      endcase
    end
  end

  // Length of the current soft-reset pulse, for the checker below.
  logic [RC_W:0] hi_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_len <= '0;
    else if (soft_rst) hi_len <= hi_len + 1'b1;
    else hi_len <= '0;
  end

  // R3: a gain frame lands on the next cycle
  p_gain_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr && addr == A_GAIN && !soft_rst |=> gain_code == $past(data));
  // R7: writes without effect leave every field alone
  p_unmapped_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr && !has_effect(addr, data) && !soft_rst |=>
      $stable({gain_code, tgt_offset, blk_dly, pix_dly, clk_opts,
               ctl_bits, cal_bits, fine_dac, coarse_dac}));
  // R9: the pulse starts only from a reset frame
  p_pulse_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(soft_rst) |-> $past(wr && addr == A_RST && data[0]));
  // R9: registers are at defaults after every pulse cycle
  p_pulse_defaults_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> gain_code == D_GAIN && tgt_offset == D_TGT &&
                 clk_opts == D_CLK && ctl_bits == D_CTL && cal_bits == D_CAL &&
                 fine_dac == '0 && coarse_dac == '0 && blk_dly == '0);
  // R9: the pulse lasts the configured number of cycles
  p_pulse_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(soft_rst) |-> hi_len == (RC_W+1)'(RST_CYCLES));
endmodule

// File: rtl/ser_ctrl_regs.sv
module ser_ctrl_regs
  import ser_regs_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk,
  input  logic       ser_din,
  input  logic       ser_load,
  output logic [7:0] gain_code,
  output logic [5:0] tgt_offset,
  output logic [2:0] blk_dly,
  output logic [2:0] pix_dly,
  output logic [6:0] clk_opts,
  output logic [3:0] ctl_bits,
  output logic [4:0] cal_bits,
  output logic [9:0] fine_dac,
  output logic [3:0] coarse_dac,
  output logic       soft_rst
);
  logic [2:0]        pin_lvl, pin_rise;
  logic              frame_wr;
  logic [ADDR_W-1:0] frame_addr;
  logic [DATA_W-1:0] frame_data;

  ser_edge_sync #(.W(3)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  ({ser_load, ser_din, ser_clk}),
    .lvl  (pin_lvl),
    .rise (pin_rise)
  );

  ser_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .din_lvl   (pin_lvl[1]),
    .sclk_rise (pin_rise[0]),
    .load_lvl  (pin_lvl[2]),
    .load_rise (pin_rise[2]),
    .frame_wr  (frame_wr),
    .frame_addr(frame_addr),
    .frame_data(frame_data)
  );

  ser_reg_bank #(.RST_CYCLES(RST_CYCLES)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (frame_wr),
    .addr      (frame_addr),
    .data      (frame_data),
    .gain_code (gain_code),
    .tgt_offset(tgt_offset),
    .blk_dly   (blk_dly),
    .pix_dly   (pix_dly),
    .clk_opts  (clk_opts),
    .ctl_bits  (ctl_bits),
    .cal_bits  (cal_bits),
    .fine_dac  (fine_dac),
    .coarse_dac(coarse_dac),
    .soft_rst  (soft_rst)
  );
endmodule

// File: tb/sim_ser_ctrl_regs.sv
module sim_ser_ctrl_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_din = 1'b0, ser_load = 1'b1;
  logic [7:0] gain_code;
  logic [5:0] tgt_offset;
  logic [2:0] blk_dly, pix_dly;
  logic [6:0] clk_opts;
  logic [3:0] ctl_bits;
  logic [4:0] cal_bits;
  logic [9:0] fine_dac;
  logic [3:0] coarse_dac;
  logic       soft_rst;

  int n_chk = 0, n_fail = 0, cyc = 0;

  // expected model
  logic [7:0] e_gain;
  logic [5:0] e_tgt;
  logic [2:0] e_blk, e_pix;
  logic [6:0] e_clk;
  logic [3:0] e_ctl;
  logic [4:0] e_cal;
  logic [9:0] e_fine;
  logic [3:0] e_crs;

  always #2 clk = ~clk;

  ser_ctrl_regs u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_load(ser_load), .gain_code(gain_code), .tgt_offset(tgt_offset),
    .blk_dly(blk_dly), .pix_dly(pix_dly), .clk_opts(clk_opts),
    .ctl_bits(ctl_bits), .cal_bits(cal_bits), .fine_dac(fine_dac),
    .coarse_dac(coarse_dac), .soft_rst(soft_rst)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic set_defaults();
    e_gain = 8'd0; e_tgt = 6'd32; e_blk = 3'd0; e_pix = 3'd0;
    e_clk = 7'h10; e_ctl = 4'h1; e_cal = 5'h0C; e_fine = 10'd0; e_crs = 4'd0;
  endtask

  task automatic model_write(input logic [3:0] a, input logic [7:0] d);
    case (a)
      4'd0: e_gain = d;
      4'd1: e_tgt = d % 64;
      4'd2: begin e_blk = d / 32; e_pix = (d / 4) % 8; end
      4'd3: e_clk = d % 128;
      4'd4: e_ctl = d % 16;
      4'd5: e_cal = d % 32;
      4'd6: e_fine = d * 4 + (e_fine % 4);
      4'd7: e_fine = (e_fine / 4) * 4 + (d % 4);
      4'd8: e_crs = d % 16;
      4'd15: if (d % 2 == 1) set_defaults();
      default: ;
    endcase
  endtask

  task automatic check_all(input string req);
    chk({req, " gain"}, 32'(gain_code), 32'(e_gain));
    chk({req, " target"}, 32'(tgt_offset), 32'(e_tgt));
    chk({req, " blk_dly"}, 32'(blk_dly), 32'(e_blk));
    chk({req, " pix_dly"}, 32'(pix_dly), 32'(e_pix));
    chk({req, " clk_opts"}, 32'(clk_opts), 32'(e_clk));
    chk({req, " ctl"}, 32'(ctl_bits), 32'(e_ctl));
    chk({req, " cal"}, 32'(cal_bits), 32'(e_cal));
    chk({req, " fine"}, 32'(fine_dac), 32'(e_fine));
    chk({req, " coarse"}, 32'(coarse_dac), 32'(e_crs));
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sclk(input logic b);
    @(negedge clk); ser_din = b;
    wait_neg(3); ser_clk = 1'b1;
    wait_neg(4); ser_clk = 1'b0;
    wait_neg(3);
  endtask

  // Shifts nbits of {a,d} MSB first (zeros beyond 12), then raises load.
  task automatic send_bits(input logic [3:0] a, input logic [7:0] d, input int nbits);
    logic [11:0] fr;
    fr = {a, d};
    @(negedge clk); ser_load = 1'b0;
    wait_neg(4);
    for (int i = 0; i < nbits; i++) pulse_sclk(i < 12 ? fr[11-i] : 1'b0);
    @(negedge clk); ser_load = 1'b1;
  endtask

  task automatic write(input logic [3:0] a, input logic [7:0] d);
    send_bits(a, d, 12);
    model_write(a, d);
    wait_neg(12);
  endtask

  initial begin
    set_defaults();
    wait_neg(5);
    rst_n = 1'b1;
    wait_neg(5);
    // R2 reset state
    check_all("R2");
    chk("R2 soft_rst", 32'(soft_rst), 32'd0);

    // R1 R3: exhaustive gain sweep checks bit order and width
    for (int g = 0; g < 256; g++) begin
      write(4'd0, 8'(g));
      chk("R1 R3 gain sweep", 32'(gain_code), 32'(e_gain));
    end
    // R3: target discards upper two bits
    write(4'd1, 8'hFF); check_all("R3 target ff");
    write(4'd1, 8'h85); check_all("R3 target 85");
    // R4: delay fields
    for (int v = 0; v < 256; v += 37) begin
      write(4'd2, 8'(v)); check_all("R4 delay");
    end
    // R5: clock, control, calibration
    write(4'd3, 8'hCA); check_all("R5 clock");
    write(4'd5, 8'hF3); check_all("R5 cal");
    write(4'd4, 8'hF5); check_all("R5 ctl");
    // R6: fine DAC halves, coarse DAC
    for (int v = 0; v < 256; v += 29) begin
      write(4'd6, 8'(v)); chk("R6 fine hi", 32'(fine_dac), 32'(e_fine));
      write(4'd7, 8'(255 - v)); chk("R6 fine lo", 32'(fine_dac), 32'(e_fine));
    end
    write(4'd8, 8'hA9); check_all("R6 coarse");
    // R7: addresses with no effect
    for (int a = 9; a < 15; a++) begin
      write(4'(a), 8'hFF); check_all("R7 undefined addr");
    end
    write(4'd15, 8'hFE); check_all("R7 reset bit clear");
    chk("R7 soft_rst idle", 32'(soft_rst), 32'd0);
    // R8: short and long frames are dropped
    send_bits(4'd0, 8'h33, 11); wait_neg(12); check_all("R8 eleven bits");
    send_bits(4'd0, 8'h33, 13); wait_neg(12); check_all("R8 thirteen bits");
    send_bits(4'd0, 8'h33, 0);  wait_neg(12); check_all("R8 zero bits");
    // R11: clock edges with load high are not counted
    for (int k = 0; k < 3; k++) pulse_sclk(1'b1);
    write(4'd0, 8'h6C); check_all("R11 idle clocks");
    // R12: load edge and shift-clock edge in one cycle
    begin
      logic [11:0] fr;
      fr = {4'd0, 8'hC3};
      @(negedge clk); ser_load = 1'b0; wait_neg(4);
      for (int i = 0; i < 12; i++) pulse_sclk(fr[11-i]);
      @(negedge clk); ser_clk = 1'b1; ser_load = 1'b1;
      wait_neg(4); ser_clk = 1'b0;
      model_write(4'd0, 8'hC3);
      wait_neg(8);
      check_all("R12 simultaneous edges");
    end
    // R10: power down keeps values and port stays live
    write(4'd4, 8'h02); check_all("R10 power down set");
    write(4'd0, 8'h5A); check_all("R10 write while powered down");
    // R9: soft reset pulse length and defaults
    begin
      int hi = 0;
      send_bits(4'd15, 8'h01, 12);
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (soft_rst) hi++;
      end
      set_defaults();
      chk("R9 pulse length", 32'(hi), 32'd4);
      chk("R9 self clear", 32'(soft_rst), 32'd0);
      check_all("R9 defaults");
    end
    write(4'd0, 8'h11); check_all("R9 writes after reset");
    finish_run();
  end
endmodule